// File: doc/BRIEF.md
# Masked Content-Addressable Match Array

This block is a small associative store of `WORDS` entries, each `WIDTH` bits wide, that is searched by content instead of by address. A write port fills entries by index, and each write also marks its entry as occupied. A search presents a search value together with a per-bit care mask. In one cycle every occupied entry is compared against the search value, but only on the bit positions where the mask holds 1. The outcome is latched as a hit vector with one bit per entry.

After a search, the block streams out the hitting entries without being asked. It sends one entry per cycle, from the lowest index to the highest, and gives the index and the stored word for each. A pulse marks the last entry sent. If a search finds nothing, the block raises a miss flag and sends no entries. A new search starts over at once and drops any stream still in progress. Writes made while entries are streaming leave the latched hit vector as it was.

Top module: `cam_match_array`

## Requirements
- R1: After reset, `hit_vec` is all zeros, `miss` is 0, `res_valid` is 0, `res_last` is 0, and every entry is unoccupied.
- R2: A write with `wr_en`=1 stores `wr_data` at `wr_addr` and marks that entry occupied. An unoccupied entry never hits, even when `srch_mask` is all zeros.
- R3: Bit positions where `srch_mask` is 0 are ignored in the comparison. Bit positions where it is 1 must equal `srch_value`.
- R4: In the cycle after a search (`srch_en`=1 at a rising edge), `hit_vec[i]` is 1 exactly when entry i is occupied and matches under the mask. The vector holds that value until the next search or reset.
- R5: A search with no hitting entry leaves `hit_vec` at all zeros and sets `miss` to 1. `miss` stays at that value until the next search. No result beat follows such a search.
- R6: Starting in the second cycle after a search, one hitting entry is sent per cycle, in ascending index order. Each is sent with `res_valid`=1, its index on `res_addr` and its stored word on `res_data`.
- R7: `res_last` is 1 together with the beat for the highest-index hit, and only then. `res_valid` is 0 in the cycle after that beat.
- R8: A write that lands while results are streaming leaves `hit_vec` unchanged.
- R9: A search issued while results are streaming drops the remaining beats. Streaming then restarts with the hits of the new search.
- R10: A search and a write in the same cycle compare against the contents as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Entry index to write |
| wr_data | input | WIDTH | Word to store |
| srch_en | input | 1 | Search strobe |
| srch_value | input | WIDTH | Search value |
| srch_mask | input | WIDTH | Care mask, 1 = compare this bit |
| hit_vec | output | WORDS | Latched per-entry hit flags |
| miss | output | 1 | Last search found no entry |
| res_valid | output | 1 | Result beat present |
| res_addr | output | AW | Index of the entry in this beat |
| res_data | output | WIDTH | Stored word of the entry in this beat |
| res_last | output | 1 | Beat is the final hit of the search |
| busy | output | 1 | Hits remain to be streamed |

## Verification
The bench searches with masks that are full, partial, low-nibble only and all zero. The all-zero mask exposes a design that lets never-written entries hit, because such a design would report the top entries as matches. Each search's streamed beats are checked for order, for the data sent and for the position of the final-beat pulse. A scan that skipped an entry, ran backwards or flagged the final beat one cycle late would fail these checks. Directed cases write an entry during streaming, cut off a stream with a new search, and issue a search in the same cycle as a write. These catch a hit vector that tracks live contents, a stream that finishes the old search, and a compare that sees data still being written.

// File: rtl/cam_pkg.sv
package cam_pkg;
  parameter int unsigned CAM_WORDS_DEF = 8;
  parameter int unsigned CAM_WIDTH_DEF = 12;

  function automatic int unsigned addr_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WIDTH = 12,
  localparam int unsigned AW = cam_pkg::addr_bits(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] cmp_value,
  input  logic [WIDTH-1:0] cmp_mask,
  output logic [WORDS-1:0] hits,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [WORDS];
  logic [WORDS-1:0] occ;

  // storage has no reset so it maps to plain registers or distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else if (wr_en) occ[wr_addr] <= 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < WORDS; gi++) begin : g_cmp
      assign hits[gi] = occ[gi] & (((mem[gi] ^ cmp_value) & cmp_mask) == '0);
    end
  endgenerate

  assign rd_data = mem[rd_addr];

  AST_WRITE_OCCUPIES: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) |-> occ[$past(wr_addr)]); // R2
endmodule

// File: rtl/cam_hit_latch.sv
module cam_hit_latch #(
  parameter int unsigned WORDS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WORDS-1:0] hits,
  output logic [WORDS-1:0] hit_vec,
  output logic             miss
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_vec <= '0;
      miss    <= 1'b0;
    end else if (start) begin
      hit_vec <= hits;
      miss    <= (hits == '0);
    end
  end

  AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(start) && !$past(rst) |-> $stable(hit_vec)); // R8
  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(start) && !$past(rst) |-> $stable(miss)); // R5
endmodule

// File: rtl/cam_scan.sv
module cam_scan #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WIDTH = 12,
  localparam int unsigned AW = cam_pkg::addr_bits(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WORDS-1:0] hits,
  input  logic [WORDS-1:0] hit_vec,
  output logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] rd_data,
  output logic             res_valid,
  output logic [AW-1:0]    res_addr,
  output logic [WIDTH-1:0] res_data,
  output logic             res_last,
  output logic             busy
);
  logic [WORDS-1:0] pend;
  logic [WORDS-1:0] pend_next;
  logic [AW-1:0]    low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (pend[i]) low_idx = AW'(i);
    end
    pend_next = pend;
    pend_next[low_idx] = 1'b0;
  end

  assign rd_addr = low_idx;
  assign busy    = (pend != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      res_valid <= 1'b0;
      res_last  <= 1'b0;
      res_addr  <= '0;
      res_data  <= '0;
    end else if (start) begin
      pend      <= hits;
      res_valid <= 1'b0;
      res_last  <= 1'b0;
    end else if (pend != '0) begin
      pend      <= pend_next;
      res_valid <= 1'b1;
      res_addr  <= low_idx;
      res_data  <= rd_data;
      res_last  <= (pend_next == '0);
    end else begin
      res_valid <= 1'b0;
      res_last  <= 1'b0;
    end
  end

  AST_BEAT_IS_HIT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> hit_vec[res_addr]); // R6
  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(res_valid) |-> res_addr > $past(res_addr)); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    res_last |=> !res_valid); // R7
  AST_LAST_HAS_BEAT: assert property (@(posedge clk) disable iff (rst)
    res_last |-> res_valid); // R7
endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
  parameter int unsigned WORDS = cam_pkg::CAM_WORDS_DEF,
  parameter int unsigned WIDTH = cam_pkg::CAM_WIDTH_DEF,
  localparam int unsigned AW = cam_pkg::addr_bits(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             srch_en,
  input  logic [WIDTH-1:0] srch_value,
  input  logic [WIDTH-1:0] srch_mask,
  output logic [WORDS-1:0] hit_vec,
  output logic             miss,
  output logic             res_valid,
  output logic [AW-1:0]    res_addr,
  output logic [WIDTH-1:0] res_data,
  output logic             res_last,
  output logic             busy
);
  logic [WORDS-1:0] hits;
  logic [AW-1:0]    rd_addr;
  logic [WIDTH-1:0] rd_data;

  cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_value(srch_value), .cmp_mask(srch_mask), .hits(hits),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cam_hit_latch #(.WORDS(WORDS)) u_latch (
    .clk(clk), .rst(rst), .start(srch_en), .hits(hits),
    .hit_vec(hit_vec), .miss(miss)
  );

  cam_scan #(.WORDS(WORDS), .WIDTH(WIDTH)) u_scan (
    .clk(clk), .rst(rst), .start(srch_en), .hits(hits), .hit_vec(hit_vec),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .res_valid(res_valid), .res_addr(res_addr), .res_data(res_data),
    .res_last(res_last), .busy(busy)
  );

  AST_MISS_MEANS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    miss |-> !res_valid && !busy); // R5
endmodule

// File: tb/sim_cam_match_array.sv
module sim_cam_match_array;
  localparam int WORDS = 8;
  localparam int WIDTH = 12;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic srch_en = 1'b0;
  logic [WIDTH-1:0] srch_value = '0;
  logic [WIDTH-1:0] srch_mask = '0;
  logic [WORDS-1:0] hit_vec;
  logic miss, res_valid, res_last, busy;
  logic [AW-1:0] res_addr;
  logic [WIDTH-1:0] res_data;

  int checks = 0;
  int fails = 0;
  logic [WIDTH-1:0] model [WORDS];

  always #2.5 clk = ~clk;

  cam_match_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .srch_en(srch_en), .srch_value(srch_value), .srch_mask(srch_mask),
    .hit_vec(hit_vec), .miss(miss), .res_valid(res_valid), .res_addr(res_addr),
    .res_data(res_data), .res_last(res_last), .busy(busy)
  );

  // {mask, value, expected hit vector}
  localparam logic [31:0] VECS [6] = '{
    {12'hFFF, 12'h123, 8'b0000_0101},
    {12'hFF0, 12'h120, 8'b0010_0101},
    {12'h00F, 12'h003, 8'b0001_0101},
    {12'h000, 12'h000, 8'b0011_1111},
    {12'hFFF, 12'h789, 8'b0000_0000},
    {12'h0FF, 12'h0FF, 8'b0000_1000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input int a, input logic [WIDTH-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  // launch a search; returns after the latch edge
  task automatic search(input logic [WIDTH-1:0] m, input logic [WIDTH-1:0] v);
    srch_en = 1'b1; srch_mask = m; srch_value = v;
    @(negedge clk);
    srch_en = 1'b0;
  endtask

  // check latched result and the full stream that follows
  task automatic expect_stream(input logic [WORDS-1:0] ev);
    int remaining;
    chk(hit_vec == ev, "R4", 32'(hit_vec), 32'(ev));
    chk(miss == (ev == '0), "R5", 32'(miss), 32'(ev == '0));
    remaining = $countones(ev);
    for (int i = 0; i < WORDS; i++) begin
      if (ev[i]) begin
        @(negedge clk);
        remaining--;
        chk(res_valid == 1'b1, "R6", 32'(res_valid), 32'd1);
        chk(res_addr == AW'(i), "R6", 32'(res_addr), 32'(i));
        chk(res_data == model[i], "R6", 32'(res_data), 32'(model[i]));
        chk(res_last == (remaining == 0), "R7", 32'(res_last), 32'(remaining == 0));
      end
    end
    @(negedge clk);
    chk(res_valid == 1'b0, (ev == '0) ? "R5" : "R7", 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(hit_vec == '0, "R1", 32'(hit_vec), 32'd0);
    chk(miss == 1'b0, "R1", 32'(miss), 32'd0);
    chk(res_valid == 1'b0 && res_last == 1'b0, "R1", 32'({res_valid, res_last}), 32'd0);
    // R1/R2: nothing occupied, mask zero matches nothing
    search(12'h000, 12'h000);
    expect_stream('0);

    write_word(0, 12'h123); write_word(1, 12'h456); write_word(2, 12'h123);
    write_word(3, 12'h1FF); write_word(4, 12'h0F3); write_word(5, 12'h120);

    // R2 R3 R4: table of masked searches
    for (int k = 0; k < 6; k++) begin
      search(VECS[k][31:20], VECS[k][19:8]);
      expect_stream(VECS[k][7:0]);
    end

    // R8: write entry 1 to a matching word during the stream
    search(12'hFFF, 12'h123);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 12'h123;
    @(negedge clk);
    wr_en = 1'b0; model[1] = 12'h123;
    chk(hit_vec == 8'b0000_0101, "R8", 32'(hit_vec), 32'h05);
    chk(res_valid && res_addr == 3'd0, "R8", 32'(res_addr), 32'd0);
    @(negedge clk);
    chk(res_valid && res_addr == 3'd2 && res_last, "R8", 32'(res_addr), 32'd2);
    chk(hit_vec == 8'b0000_0101, "R8", 32'(hit_vec), 32'h05);
    @(negedge clk);
    search(12'hFFF, 12'h123);
    expect_stream(8'b0000_0111);

    // R9: restart mid-stream
    search(12'h000, 12'h000);
    @(negedge clk);
    chk(res_valid && res_addr == 3'd0, "R9", 32'(res_addr), 32'd0);
    search(12'h0FF, 12'h0FF);
    chk(res_valid == 1'b0, "R9", 32'(res_valid), 32'd0);
    expect_stream(8'b0000_1000);

    // R10: search in same cycle as a write to entry 6
    srch_en = 1'b1; srch_mask = 12'hFFF; srch_value = 12'h789;
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = 12'h789;
    @(negedge clk);
    srch_en = 1'b0; wr_en = 1'b0; model[6] = 12'h789;
    chk(hit_vec == '0 && miss, "R10", 32'(hit_vec), 32'd0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10", 32'(res_valid), 32'd0);
    search(12'hFFF, 12'h789);
    expect_stream(8'b0100_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule